// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Sequencer

This block drives a read transaction on a serial flash port that has up to four bidirectional data lines. Its configuration inputs set the lane format (one, two or four lines), which of the early phases use the wide format, the command length, the address length, the number of idle turnaround cycles and the number of data frames to fetch. Two writes to the data port start a read: the first word carries the command, the second word carries the address. The block then asserts select, shifts out the command and the address, waits out the turnaround cycles with every line released, and gathers the returned bits into frames that it stores in a receive FIFO.

Each serial bit slot takes one clock cycle; any clock division sits outside this block. A DMA engine or a CPU drains the FIFO through a simple read strobe. When receive DMA is enabled, the block raises a request once the FIFO holds more frames than the programmed watermark. Sticky overflow and underflow flags report FIFO misuse. The next command write clears both flags.

Top module: `qspi_rd_seq`

## Requirements
- R1: After reset, ss_n is 1, busy is 0, io_oe is 0, rx_level is 0, and dma_req, rx_ovf and rx_unf are all 0.
- R2: While idle, the first accepted wr_valid word is the command and the second is the address. ss_n falls in the cycle after the second write. No phase starts after only one write. Writes that arrive while busy is 1 are ignored and do not disturb the current or the next transaction.
- R3: Phases run in the order command, address, turnaround, data, and a phase of zero length is skipped. cmd_len selects the command length: 0 gives none, 1 gives 4 bits, 2 gives 8 bits and 3 gives 16 bits. The address length is 4 × addr_nib bits, so 6 gives 24 bits, 8 gives 32 bits, 0 skips the phase, and the valid range is 0 to 8. The turnaround lasts wait_cyc cycles, and io_oe is 0 during it and during the data phase.
- R4: lane_fmt 0, 1 and 2 select 1, 2 and 4 data lanes. xfer_type 0 sends the command and the address on one lane. xfer_type 1 sends the command on one lane and the address on the lane format. xfer_type 2 sends both on the lane format. The data phase always uses the lane format. Each driven cycle sets io_oe to 0001, 0011 or 1111 for 1, 2 or 4 lanes.
- R5: Fields are sent MSB first, and the command and address are taken from the low bits of their words. With one lane, data goes out on io_out[0] and is sampled from io_in[1]. With two lanes, line 1 carries the higher bit. With four lanes, lines 3..0 carry bits 3..0 of each nibble.
- R6: The data phase gathers frames_m1+1 frames of FRAME_W bits, MSB first, and then ss_n rises. busy stays 1 for exactly one more cycle.
- R7: rd_data shows the oldest stored frame. Each rd_en on a non-empty FIFO removes one frame. Frames come out in arrival order, and rx_level counts the frames held.
- R8: A frame that completes while the FIFO holds FIFO_DEPTH frames is dropped and sets rx_ovf. rx_ovf stays set until the next command write.
- R9: rd_en on an empty FIFO sets rx_unf and leaves rx_level at 0. rx_unf stays set until the next command write.
- R10: dma_req is 1 exactly when dma_en[0] is 1 and rx_level ≥ dma_wm+1. dma_en[1] (transmit DMA enable) has no effect on dma_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| lane_fmt | input | 2 | Lane format: 0 single, 1 dual, 2 quad |
| xfer_type | input | 2 | Which early phases use the lane format |
| addr_nib | input | 4 | Address length in 4-bit units |
| cmd_len | input | 2 | Command length code |
| wait_cyc | input | 5 | Turnaround cycles |
| frames_m1 | input | CNT_W | Frames to read minus one |
| dma_en | input | 2 | Bit0 receive DMA enable, bit1 transmit DMA enable |
| dma_wm | input | LVL_W-1 | DMA watermark |
| wr_valid | input | 1 | Data port write strobe |
| wr_data | input | 32 | Command or address word |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | FRAME_W | Oldest FIFO frame |
| rx_level | output | LVL_W | Frames held in the FIFO |
| dma_req | output | 1 | Receive DMA request |
| rx_ovf | output | 1 | Sticky overflow flag |
| rx_unf | output | 1 | Sticky underflow flag |
| ss_n | output | 1 | Active-low select |
| busy | output | 1 | Transaction in progress |
| io_out | output | 4 | Line output values |
| io_oe | output | 4 | Line output enables |
| io_in | input | 4 | Line input values |

## Verification
A wrong phase state or a wrong phase counter shows up at io_oe or io_out in the first cycle it affects, because the lane mask and the driven bits are compared in every cycle of a transaction. A wrong frame counter or a wrong deserializer bit count shows up as an early or late rise of ss_n, or as a wrong rx_level when the transaction ends. A corrupted FIFO pointer shows up on rd_data at the first read that follows. Flag and watermark faults show up as soon as the level crosses the threshold or a read hits an empty FIFO.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ARMED, PH_CMD, PH_ADR, PH_GAP, PH_RX, PH_END
    } phase_e;

    typedef struct packed {
        logic [1:0] lane_fmt;
        logic [1:0] xtype;
        logic [3:0] adr_nib;
        logic [1:0] cmd_code;
        logic [4:0] gap_cyc;
    } seq_cfg_t;

    // log2 of the lane count for a format code
    function automatic logic [1:0] fmt_log(input logic [1:0] fmt);
        case (fmt)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [4:0] cmd_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd0;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [1:0] phase_log(input phase_e ph, input seq_cfg_t c);
        case (ph)
            PH_CMD:  return (c.xtype == 2'd2) ? fmt_log(c.lane_fmt) : 2'd0;
            PH_ADR:  return (c.xtype == 2'd1 || c.xtype == 2'd2) ? fmt_log(c.lane_fmt) : 2'd0;
            PH_RX:   return fmt_log(c.lane_fmt);
            default: return 2'd0;
        endcase
    endfunction

    // cycles spent in a counted phase
    function automatic logic [5:0] phase_len(input phase_e ph, input seq_cfg_t c);
        case (ph)
            PH_CMD:  return {1'b0, cmd_bits(c.cmd_code)} >> phase_log(ph, c);
            PH_ADR:  return {c.adr_nib, 2'b00} >> phase_log(ph, c);
            PH_GAP:  return {1'b0, c.gap_cyc};
            default: return 6'd0;
        endcase
    endfunction

    // next non-empty phase
    function automatic phase_e after(input phase_e ph, input seq_cfg_t c);
        logic has_cmd, has_adr, has_gap;
        has_cmd = (c.cmd_code != 2'd0);
        has_adr = (c.adr_nib != 4'd0);
        has_gap = (c.gap_cyc != 5'd0);
        case (ph)
            PH_ARMED: return has_cmd ? PH_CMD : has_adr ? PH_ADR : has_gap ? PH_GAP : PH_RX;
            PH_CMD:   return has_adr ? PH_ADR : has_gap ? PH_GAP : PH_RX;
            PH_ADR:   return has_gap ? PH_GAP : PH_RX;
            default:  return PH_RX;
        endcase
    endfunction

endpackage

// File: rtl/qrs_fifo.sv
module qrs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_flags,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic [LW-1:0] level,
    output logic          ovf,
    output logic          unf
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, empty, do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
            ovf   <= (ovf && !clr_flags) || (push && full);
            unf   <= (unf && !clr_flags) || (pop && empty);
        end
    end

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (level == LW'(DEPTH) && ovf)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (level == '0 && unf)); // R9

endmodule

// File: rtl/qrs_deser.sv
module qrs_deser #(
    parameter int FRAME_W = 8,
    localparam int BC_W   = $clog2(FRAME_W) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [1:0]         lane_lg,
    input  logic [3:0]         io_in,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] acc_q, acc_n;
    logic [BC_W-1:0]    bits_q, bits_n;

    always_comb begin
        case (lane_lg)
            2'd0:    acc_n = {acc_q[FRAME_W-2:0], io_in[1]};
            2'd1:    acc_n = {acc_q[FRAME_W-3:0], io_in[1:0]};
            default: acc_n = {acc_q[FRAME_W-5:0], io_in[3:0]};
        endcase
        bits_n = bits_q + (BC_W'(1) << lane_lg);
    end

    assign frame_done = en && (bits_n >= BC_W'(FRAME_W));
    assign frame      = acc_n;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q  <= '0;
            bits_q <= '0;
        end else begin
            acc_q  <= acc_n;
            bits_q <= frame_done ? '0 : bits_n;
        end
    end

endmodule

// File: rtl/qrs_seq.sv
module qrs_seq
    import qrs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cfg_t         cfg,
    input  logic [CNT_W-1:0] frames_m1,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    input  logic             frame_done,
    output phase_e           ph,
    output logic [1:0]       lane_lg,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    output logic             ss_n,
    output logic             busy,
    output logic             cmd_take
);
    phase_e           ph_q, nxt;
    logic [31:0]      cmd_q, adr_q, sh_q, load_val, adr_src;
    logic [5:0]       cnt_q;
    logic [CNT_W-1:0] left_q;
    logic [2:0]       lanes_n;
    logic             counted, go, active;

    assign ph       = ph_q;
    assign nxt      = after(ph_q, cfg);
    assign lane_lg  = phase_log(ph_q, cfg);
    assign lanes_n  = 3'd1 << lane_lg;
    assign counted  = (ph_q == PH_CMD) || (ph_q == PH_ADR) || (ph_q == PH_GAP);
    assign go       = (ph_q == PH_ARMED && wr_valid) || (counted && cnt_q == '0);
    assign cmd_take = (ph_q == PH_IDLE) && wr_valid;
    assign adr_src  = (ph_q == PH_ARMED) ? wr_data : adr_q;
    assign active   = counted || (ph_q == PH_RX);
    assign ss_n     = !active;
    assign busy     = active || (ph_q == PH_END);

    // left-justify the field that the next phase sends
    always_comb begin
        load_val = '0;
        case (nxt)
            PH_CMD:  load_val = cmd_q << (6'd32 - {1'b0, cmd_bits(cfg.cmd_code)});
            PH_ADR:  load_val = adr_src << (6'd32 - {cfg.adr_nib, 2'b00});
            default: load_val = '0;
        endcase
    end

    always_comb begin
        io_out = '0;
        io_oe  = '0;
        if (ph_q == PH_CMD || ph_q == PH_ADR) begin
            case (lane_lg)
                2'd0:    begin io_out = {3'b000, sh_q[31]};   io_oe = 4'b0001; end
                2'd1:    begin io_out = {2'b00, sh_q[31:30]}; io_oe = 4'b0011; end
                default: begin io_out = sh_q[31:28];          io_oe = 4'b1111; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cmd_q  <= '0;
            adr_q  <= '0;
            sh_q   <= '0;
            cnt_q  <= '0;
            left_q <= '0;
        end else if (go) begin
            ph_q  <= nxt;
            cnt_q <= phase_len(nxt, cfg) - 6'd1;
            sh_q  <= load_val;
            if (ph_q == PH_ARMED) begin
                adr_q  <= wr_data;
                left_q <= frames_m1;
            end
        end else begin
            case (ph_q)
                PH_IDLE: if (wr_valid) begin
                    cmd_q <= wr_data;
                    ph_q  <= PH_ARMED;
                end
                PH_CMD, PH_ADR, PH_GAP: begin
                    cnt_q <= cnt_q - 6'd1;
                    sh_q  <= sh_q << lanes_n;
                end
                PH_RX: if (frame_done) begin
                    if (left_q == '0) ph_q <= PH_END;
                    else              left_q <= left_q - 1'b1;
                end
                PH_END:  ph_q <= PH_IDLE;
                default: ph_q <= ph_q;
            endcase
        end
    end

    AST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> busy); // R6
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |=> !busy); // R6
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_valid) |=> $stable(cmd_q)); // R2

endmodule

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq
    import qrs_pkg::*;
#(
    parameter int FRAME_W    = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         lane_fmt,
    input  logic [1:0]         xfer_type,
    input  logic [3:0]         addr_nib,
    input  logic [1:0]         cmd_len,
    input  logic [4:0]         wait_cyc,
    input  logic [CNT_W-1:0]   frames_m1,
    input  logic [1:0]         dma_en,
    input  logic [LVL_W-2:0]   dma_wm,
    input  logic               wr_valid,
    input  logic [31:0]        wr_data,
    input  logic               rd_en,
    output logic [FRAME_W-1:0] rd_data,
    output logic [LVL_W-1:0]   rx_level,
    output logic               dma_req,
    output logic               rx_ovf,
    output logic               rx_unf,
    output logic               ss_n,
    output logic               busy,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in
);
    seq_cfg_t           cfg;
    phase_e             ph;
    logic [1:0]         lane_lg;
    logic               frame_done, cmd_take;
    logic [FRAME_W-1:0] frame;

    assign cfg = '{lane_fmt: lane_fmt, xtype: xfer_type, adr_nib: addr_nib,
                   cmd_code: cmd_len, gap_cyc: wait_cyc};

    qrs_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .cfg(cfg), .frames_m1(frames_m1),
        .wr_valid(wr_valid), .wr_data(wr_data), .frame_done(frame_done),
        .ph(ph), .lane_lg(lane_lg), .io_out(io_out), .io_oe(io_oe),
        .ss_n(ss_n), .busy(busy), .cmd_take(cmd_take)
    );

    qrs_deser #(.FRAME_W(FRAME_W)) u_deser (
        .clk(clk), .rst(rst), .en(ph == PH_RX), .lane_lg(lane_lg),
        .io_in(io_in), .frame_done(frame_done), .frame(frame)
    );

    qrs_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr_flags(cmd_take), .push(frame_done),
        .push_data(frame), .pop(rd_en), .rd_data(rd_data), .level(rx_level),
        .ovf(rx_ovf), .unf(rx_unf)
    );

    assign dma_req = dma_en[0] && (rx_level >= ({1'b0, dma_wm} + LVL_W'(1)));

    AST_DMA_LEVEL: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (rx_level != '0)); // R10

endmodule

// File: tb/sim_qspi_rd_seq.sv
module sim_qspi_rd_seq;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int FW     = 8;

    logic        clk = 1'b0, rst = 1'b1;
    logic [1:0]  lane_fmt = '0, xfer_type = '0, cmd_len = '0, dma_en = '0;
    logic [3:0]  addr_nib = '0;
    logic [4:0]  wait_cyc = '0;
    logic [15:0] frames_m1 = '0;
    logic [2:0]  dma_wm = '0;
    logic        wr_valid = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  rx_level, io_out, io_oe, io_in = '0;
    logic        dma_req, rx_ovf, rx_unf, ss_n, busy;

    qspi_rd_seq u0 (
        .clk(clk), .rst(rst), .lane_fmt(lane_fmt), .xfer_type(xfer_type),
        .addr_nib(addr_nib), .cmd_len(cmd_len), .wait_cyc(wait_cyc),
        .frames_m1(frames_m1), .dma_en(dma_en), .dma_wm(dma_wm),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rx_level(rx_level), .dma_req(dma_req),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf), .ss_n(ss_n), .busy(busy),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    always #(PERIOD / 2) clk = ~clk;

    int         total = 0, bad = 0;
    logic [7:0] model_q[$];
    bit         m_ovf = 1'b0;
    logic [7:0] rnd = 8'hA5;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic add_chunks(ref logic [3:0] eo[$], ref logic [3:0] eoe[$],
                              input logic [31:0] v, input int nbits, input int ln);
        for (int c = 0; c < nbits / ln; c++) begin
            eo.push_back(4'((v >> (nbits - ln * (c + 1))) & ((1 << ln) - 1)));
            eoe.push_back(4'((1 << ln) - 1));
        end
    endtask

    task automatic run_xfer(input logic [1:0] fmt, input logic [1:0] xt, input logic [3:0] an,
                            input logic [1:0] cc, input int wc, input int nf,
                            input logic [31:0] cw, input logic [31:0] aw, input bit poke);
        logic [3:0] eo[$];
        logic [3:0] eoe[$];
        logic [3:0] bits;
        logic [7:0] acc = '0;
        int fl, il, al, ib, pre, tot, nb = 0;
        fl = (fmt == 0) ? 1 : (fmt == 1) ? 2 : 4;
        il = (xt == 2) ? fl : 1;
        al = (xt == 1 || xt == 2) ? fl : 1;
        ib = (cc == 0) ? 0 : (cc == 1) ? 4 : (cc == 2) ? 8 : 16;
        add_chunks(eo, eoe, cw, ib, il);
        add_chunks(eo, eoe, aw, int'(an) * 4, al);
        for (int i = 0; i < wc; i++) begin eo.push_back(4'h0); eoe.push_back(4'h0); end
        pre = eo.size();
        tot = pre + (nf + 1) * FW / fl;
        @(negedge clk);
        lane_fmt = fmt; xfer_type = xt; addr_nib = an; cmd_len = cc;
        wait_cyc = 5'(wc); frames_m1 = 16'(nf);
        wr_valid = 1'b1; wr_data = cw;
        @(negedge clk);
        m_ovf = 1'b0;
        chk(rx_ovf == 1'b0, "R8 cleared by command write", rx_ovf, 0);
        chk(rx_unf == 1'b0, "R9 cleared by command write", rx_unf, 0);
        chk(ss_n == 1'b1 && busy == 1'b0, "R2 no start after one write", {ss_n, busy}, 2);
        wr_data = aw;
        @(negedge clk);
        wr_valid = 1'b0;
        for (int k = 0; k < tot; k++) begin
            chk(ss_n == 1'b0, "R3 select low through phases", ss_n, 0);
            chk(busy == 1'b1, "R6 busy during transfer", busy, 1);
            if (k < pre && eoe[k] != 4'h0) begin
                chk(io_oe == eoe[k], "R4 lane enables", io_oe, eoe[k]);
                chk(io_out == eo[k], "R5 driven bits", io_out, eo[k]);
            end else begin
                chk(io_oe == 4'h0, "R3 lines released", io_oe, 0);
            end
            wr_valid = poke && (k == 3);
            wr_data  = 32'hDEAD_BEEF;
            rnd   = {rnd[6:0], rnd[7] ^ rnd[5] ^ rnd[4] ^ rnd[3]};
            io_in = rnd[3:0];
            if (k >= pre) begin
                bits = (fl == 1) ? {3'b000, io_in[1]} : (fl == 2) ? {2'b00, io_in[1:0]} : io_in;
                acc  = 8'((acc << fl) | 8'(bits));
                nb  += fl;
                if (nb == FW) begin
                    if (model_q.size() < DEPTH) model_q.push_back(acc);
                    else m_ovf = 1'b1;
                    nb = 0;
                end
            end
            @(negedge clk);
        end
        wr_valid = 1'b0;
        chk(ss_n == 1'b1, "R6 select released after last frame", ss_n, 1);
        chk(busy == 1'b1, "R6 busy one cycle past release", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R6 busy cleared", busy, 0);
        chk(rx_level == 4'(model_q.size()), "R6 frame count", rx_level, model_q.size());
        chk(rx_ovf == m_ovf, "R8 overflow flag", rx_ovf, m_ovf);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            chk(rd_data == model_q[0], "R7 read order", rd_data, model_q[0]);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            void'(model_q.pop_front());
        end
        chk(rx_level == 4'(model_q.size()), "R7 level after reads", rx_level, model_q.size());
    endtask

    initial begin
        #(PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        dma_en = 2'b01;
        repeat (3) @(negedge clk);
        chk(ss_n == 1'b1 && busy == 1'b0, "R1 select and busy in reset", {ss_n, busy}, 2);
        rst = 1'b0;
        @(negedge clk);
        chk(ss_n == 1'b1, "R1 select idle", ss_n, 1);
        chk(busy == 1'b0, "R1 busy idle", busy, 0);
        chk(io_oe == 4'h0, "R1 lines released", io_oe, 0);
        chk(rx_level == 4'h0, "R1 empty fifo", rx_level, 0);
        chk(dma_req == 1'b0 && rx_ovf == 1'b0 && rx_unf == 1'b0, "R1 request and flags",
            {dma_req, rx_ovf, rx_unf}, 0);

        // quad, command and address wide, 24-bit address, 4 turnaround cycles, 4 frames
        dma_en = 2'b01; dma_wm = 3'd3;
        run_xfer(2'd2, 2'd2, 4'd6, 2'd2, 4, 3, 32'h0000_00EB, 32'h0012_3456, 1'b0);
        chk(dma_req == 1'b1, "R10 request at watermark+1", dma_req, 1);
        drain(1);
        chk(dma_req == 1'b0, "R10 request drops below", dma_req, 0);
        drain(3);

        // dual, command single, 32-bit wide address, no turnaround, write while busy
        dma_en = 2'b10; dma_wm = 3'd0;
        run_xfer(2'd1, 2'd1, 4'd8, 2'd2, 0, 1, 32'h0000_003B, 32'hA5C3_0F81, 1'b1);
        chk(dma_req == 1'b0, "R10 transmit enable alone", dma_req, 0);
        dma_en = 2'b01;
        #1;
        chk(dma_req == 1'b1, "R10 receive enable", dma_req, 1);
        drain(2);

        // single lane, 4-bit command, no address, 2 turnaround cycles, 10 frames overflow
        run_xfer(2'd0, 2'd0, 4'd0, 2'd1, 2, 9, 32'h0000_0009, 32'h0, 1'b1);
        drain(DEPTH);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rx_unf == 1'b1, "R9 underflow flag", rx_unf, 1);
        chk(rx_level == 4'h0, "R9 level stays zero", rx_level, 0);
        chk(rx_ovf == 1'b1, "R8 overflow flag sticky", rx_ovf, 1);

        // quad data, type 0: 16-bit command and 32-bit address on one lane, one frame
        run_xfer(2'd2, 2'd0, 4'd8, 2'd3, 1, 0, 32'h0000_9F6B, 32'h89AB_CDEF, 1'b0);
        drain(1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule